// File: doc/BRIEF.md
# Word and Byte Shared-Array Memory

This block is a byte-organized storage array that two access paths share. The data path moves 32-bit words and is addressed in word units. The instruction path returns one byte per request and is addressed in byte units. Both paths see the same bytes. A word is laid out most-significant byte first, so the byte that the instruction path reads at the lowest address of a word holds that word's top eight bits.

Reads on both paths are registered. A request strobe in one cycle produces data, a valid pulse and, if needed, an error pulse in the next cycle. An address past the end of the array raises the error output for that path and does not raise an exception. An out-of-range read returns zero, and an out-of-range write leaves the array unchanged. The array is cleared at reset, so any location that has never been written reads as zero.

Top module: `dual_view_mem`

## Requirements
- R1: A word write at word address n stores data bits 31:24 at byte 4n, bits 23:16 at byte 4n+1, bits 15:8 at byte 4n+2 and bits 7:0 at byte 4n+3.
- R2: A word read at word address n returns {byte 4n, byte 4n+1, byte 4n+2, byte 4n+3}, most significant byte first.
- R3: The word path's byte base is the word address times four. Word address n and byte addresses 4n through 4n+3 therefore reach the same storage.
- R4: The fetch path uses its address directly as a byte address, with no alignment rule, and returns 8 bits.
- R5: After reset, every location reads as zero on both paths until it is written.
- R6: A read request on either path gives a valid pulse and its data exactly one cycle later. A word write request never raises the word valid output.
- R7: A word request whose base byte address exceeds MEM_BYTES-1 raises the word error output one cycle later. If it is a read, it returns zero data. If it is a write, no byte of memory changes.
- R8: A fetch whose byte address exceeds MEM_BYTES-1 raises the fetch error output in the same cycle as the fetch valid pulse, and returns zero data.
- R9: When a fetch targets a byte that a word write updates in the same cycle, the fetch returns the byte's value from before that write.
- R10: The highest word address whose base is in range (base MEM_BYTES-4) writes and reads all four bytes without error. The next word address (base MEM_BYTES) is reported out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also clears the array |
| wp_req | input | 1 | Word path request strobe |
| wp_we | input | 1 | Word path write select (1 = write, 0 = read) |
| wp_addr | input | WADDR_W | Word address |
| wp_wdata | input | 32 | Word write data |
| wp_rdata | output | 32 | Word read data, registered |
| wp_valid | output | 1 | Word read data valid pulse |
| wp_err | output | 1 | Word path out-of-range pulse |
| fp_req | input | 1 | Fetch request strobe |
| fp_addr | input | BADDR_W | Fetch byte address |
| fp_data | output | 8 | Fetched byte, registered |
| fp_valid | output | 1 | Fetch data valid pulse |
| fp_err | output | 1 | Fetch out-of-range pulse |

## Verification
A byte stored in the wrong lane or at the wrong word shows up on the very next read of that location. The fetch path reveals the byte order of a word one cycle after the fetch, and the word path shows the reversed assembly in the cycle after its read. A write that escapes the range gate corrupts a low word silently. It becomes visible only when that word is read back, so the bench rereads word zero right after each out-of-range write. An error or valid flag that is late or missing differs from the expected pulse at the first sample after the request.

// File: rtl/dvm_pkg.sv
package dvm_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  // bit offset of the lowest bit of a lane; lane 0 is the most significant byte
  function automatic int lane_lsb(input int lane);
    return WORD_W - BYTE_W * (lane + 1);
  endfunction
endpackage

// File: rtl/dvm_store.sv
module dvm_store
  import dvm_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int WORDS  = MEM_BYTES / WORD_BYTES,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BIDX_W = WIDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_widx,
  input  word_t             wr_data,
  input  logic [WIDX_W-1:0] rd_widx,
  output word_t             rd_word,
  input  logic [BIDX_W-1:0] rd_bidx,
  output byte_t             rd_byte
);
  byte_t cell_q [MEM_BYTES];
  byte_t cell_d [MEM_BYTES];

  for (genvar i = 0; i < MEM_BYTES; i++) begin : g_cell
    localparam int LANE = i % WORD_BYTES;
    logic sel;

    always_comb begin
      sel       = wr_en && (wr_widx == WIDX_W'(i / WORD_BYTES));
      cell_d[i] = sel ? wr_data[lane_lsb(LANE) +: BYTE_W] : cell_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q[i] <= '0;
      else        cell_q[i] <= cell_d[i];
    end

    // R7
    cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_widx == WIDX_W'(i / WORD_BYTES)) |=> $stable(cell_q[i]));
  end

  logic [BIDX_W-1:0] rd_base;

  always_comb begin
    rd_base = {rd_widx, 2'b00};
    rd_word = {cell_q[rd_base], cell_q[rd_base + BIDX_W'(1)],
               cell_q[rd_base + BIDX_W'(2)], cell_q[rd_base + BIDX_W'(3)]};
    rd_byte = cell_q[rd_bidx];
  end
endmodule

// File: rtl/dvm_word_port.sv
module dvm_word_port
  import dvm_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int WADDR_W   = 8,
  localparam int WORDS  = MEM_BYTES / WORD_BYTES,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BASE_W = WADDR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               we,
  input  logic [WADDR_W-1:0] addr,
  input  word_t              wdata,
  output logic               st_wr_en,
  output logic [WIDX_W-1:0]  st_widx,
  output word_t              st_wdata,
  input  word_t              st_rword,
  output word_t              rdata,
  output logic               valid,
  output logic               err
);
  localparam logic [BASE_W-1:0] LAST = BASE_W'(MEM_BYTES - 1);

  logic [BASE_W-1:0] base;
  logic              in_range;
  logic              rd_ce;
  word_t             rdata_d, rdata_q;
  logic              valid_d, valid_q, err_d, err_q;

  always_comb begin
    base     = {addr, 2'b00};
    in_range = (base <= LAST);
    st_widx  = addr[WIDX_W-1:0];
    st_wdata = wdata;
    st_wr_en = req && we && in_range;
    rd_ce    = req && !we;
    valid_d  = rd_ce;
    err_d    = req && !in_range;
    rdata_d  = in_range ? st_rword : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (rd_ce) rdata_q <= rdata_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign rdata = rdata_q;
  assign valid = valid_q;
  assign err   = err_q;

  // R6
  wread_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> valid_q);
  // R6
  wwrite_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |=> !valid_q);
  // R7
  wrange_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && (base > LAST)) |=> (err_q && rdata_q == '0));
  // R7
  wrange_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base > LAST) |-> !st_wr_en);
endmodule

// File: rtl/dvm_fetch_port.sv
module dvm_fetch_port
  import dvm_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int BADDR_W   = 9,
  localparam int BIDX_W = $clog2(MEM_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [BADDR_W-1:0] addr,
  output logic [BIDX_W-1:0]  st_bidx,
  input  byte_t              st_rbyte,
  output byte_t              data,
  output logic               valid,
  output logic               err
);
  localparam logic [BADDR_W-1:0] LAST = BADDR_W'(MEM_BYTES - 1);

  logic  in_range;
  byte_t data_d, data_q;
  logic  valid_d, valid_q, err_d, err_q;

  always_comb begin
    in_range = (addr <= LAST);
    st_bidx  = addr[BIDX_W-1:0];
    valid_d  = req;
    err_d    = req && !in_range;
    data_d   = in_range ? st_rbyte : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (req) data_q <= data_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign err   = err_q;

  // R6
  fvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> valid_q);
  // R8
  frange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !in_range) |=> (err_q && valid_q && data_q == '0));
  // R8
  ferr_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> valid_q);
endmodule

// File: rtl/dual_view_mem.sv
module dual_view_mem
  import dvm_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int WADDR_W   = 8,
  parameter int BADDR_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp_req,
  input  logic               wp_we,
  input  logic [WADDR_W-1:0] wp_addr,
  input  logic [31:0]        wp_wdata,
  output logic [31:0]        wp_rdata,
  output logic               wp_valid,
  output logic               wp_err,
  input  logic               fp_req,
  input  logic [BADDR_W-1:0] fp_addr,
  output logic [7:0]         fp_data,
  output logic               fp_valid,
  output logic               fp_err
);
  localparam int WORDS  = MEM_BYTES / WORD_BYTES;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int BIDX_W = WIDX_W + 2;

  logic              st_wr_en;
  logic [WIDX_W-1:0] st_widx;
  word_t             st_wdata, st_rword;
  logic [BIDX_W-1:0] st_bidx;
  byte_t             st_rbyte;

  dvm_store #(.MEM_BYTES(MEM_BYTES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (st_wr_en),
    .wr_widx (st_widx),
    .wr_data (st_wdata),
    .rd_widx (st_widx),
    .rd_word (st_rword),
    .rd_bidx (st_bidx),
    .rd_byte (st_rbyte)
  );

  dvm_word_port #(.MEM_BYTES(MEM_BYTES), .WADDR_W(WADDR_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (wp_req),
    .we       (wp_we),
    .addr     (wp_addr),
    .wdata    (wp_wdata),
    .st_wr_en (st_wr_en),
    .st_widx  (st_widx),
    .st_wdata (st_wdata),
    .st_rword (st_rword),
    .rdata    (wp_rdata),
    .valid    (wp_valid),
    .err      (wp_err)
  );

  dvm_fetch_port #(.MEM_BYTES(MEM_BYTES), .BADDR_W(BADDR_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (fp_req),
    .addr     (fp_addr),
    .st_bidx  (st_bidx),
    .st_rbyte (st_rbyte),
    .data     (fp_data),
    .valid    (fp_valid),
    .err      (fp_err)
  );

  // R9: a fetch of a byte being written in the same cycle returns the old value
  rbw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && fp_req && fp_addr < BADDR_W'(MEM_BYTES)
     && fp_addr[BIDX_W-1:2] == st_widx) |=> (fp_data == $past(st_rbyte)));
endmodule

// File: tb/sim_dual_view_mem.sv
module sim_dual_view_mem;
  localparam int  MEM_BYTES = 256;
  localparam int  WADDR_W   = 8;
  localparam int  BADDR_W   = 9;
  localparam int  WORDS     = MEM_BYTES / 4;
  localparam time CLK_PER   = 10ns;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wp_req, wp_we;
  logic [WADDR_W-1:0] wp_addr;
  logic [31:0]        wp_wdata, wp_rdata;
  logic               wp_valid, wp_err;
  logic               fp_req;
  logic [BADDR_W-1:0] fp_addr;
  logic [7:0]         fp_data;
  logic               fp_valid, fp_err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [7:0] mdl [MEM_BYTES];

  always #(CLK_PER/2) clk = ~clk;

  dual_view_mem #(.MEM_BYTES(MEM_BYTES), .WADDR_W(WADDR_W), .BADDR_W(BADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wp_req(wp_req), .wp_we(wp_we), .wp_addr(wp_addr), .wp_wdata(wp_wdata),
    .wp_rdata(wp_rdata), .wp_valid(wp_valid), .wp_err(wp_err),
    .fp_req(fp_req), .fp_addr(fp_addr), .fp_data(fp_data),
    .fp_valid(fp_valid), .fp_err(fp_err)
  );

  function automatic logic [31:0] exp_word(input int wa);
    if (wa * 4 > MEM_BYTES - 1) return '0;
    return {mdl[4*wa], mdl[4*wa+1], mdl[4*wa+2], mdl[4*wa+3]};
  endfunction

  function automatic logic [7:0] exp_byte(input int ba);
    if (ba > MEM_BYTES - 1) return '0;
    return mdl[ba];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle at a negedge, check outputs at the following negedge
  task automatic step(input bit wr, input bit wwe, input int wa, input logic [31:0] wd,
                      input bit fr, input int fa, input string tag);
    logic [31:0] ew;
    logic [7:0]  eb;
    bit          werr, ferr;
    wp_req = wr; wp_we = wwe; wp_addr = WADDR_W'(wa); wp_wdata = wd;
    fp_req = fr; fp_addr = BADDR_W'(fa);
    ew   = exp_word(wa);
    eb   = exp_byte(fa);
    werr = wr && (wa * 4 > MEM_BYTES - 1);
    ferr = fr && (fa > MEM_BYTES - 1);
    if (wr && wwe && !werr) begin
      mdl[4*wa]   = wd[31:24];
      mdl[4*wa+1] = wd[23:16];
      mdl[4*wa+2] = wd[15:8];
      mdl[4*wa+3] = wd[7:0];
    end
    @(negedge clk);
    chk(wp_valid == (wr && !wwe), tag, "wp_valid", 32'(wp_valid), 32'(wr && !wwe));
    chk(wp_err == werr, tag, "wp_err", 32'(wp_err), 32'(werr));
    if (wr && !wwe) chk(wp_rdata == ew, tag, "wp_rdata", wp_rdata, ew);
    chk(fp_valid == fr, tag, "fp_valid", 32'(fp_valid), 32'(fr));
    chk(fp_err == ferr, tag, "fp_err", 32'(fp_err), 32'(ferr));
    if (fr) chk(fp_data == eb, tag, "fp_data", 32'(fp_data), 32'(eb));
  endtask

  task automatic idle();
    wp_req = 1'b0; fp_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mdl[i] = '0;
    rst_n = 1'b0; wp_req = 1'b0; wp_we = 1'b0; wp_addr = '0; wp_wdata = '0;
    fp_req = 1'b0; fp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5: reset state of the outputs
    chk(!wp_valid && !wp_err && wp_rdata == 0, "R5", "word outputs after reset",
        {wp_rdata[31:2], wp_valid, wp_err}, 0);
    chk(!fp_valid && !fp_err && fp_data == 0, "R5", "fetch outputs after reset",
        {22'd0, fp_data, fp_valid, fp_err}, 0);
    // R5: unwritten locations read zero
    step(1, 0, 10, 0, 1, 37, "R5");
    // R1, R3: big-endian layout seen through the fetch path
    step(1, 1, 0, 32'h1122_3344, 0, 0, "R1");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, k, "R1");
    step(1, 1, 5, 32'hA1B2_C3D4, 1, 3, "R3");
    step(0, 0, 0, 0, 1, 21, "R3");
    // R2: word reassembly
    step(1, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 5, 0, 0, 0, "R2");
    // R4: unaligned byte fetches
    step(0, 0, 0, 0, 1, 22, "R4");
    step(0, 0, 0, 0, 1, 1, "R4");
    // R6: write never pulses valid, read latency one cycle then idle
    step(1, 1, 7, 32'hDEAD_BEEF, 0, 0, "R6");
    step(1, 0, 7, 0, 1, 29, "R6");
    idle();
    chk(!wp_valid && !fp_valid, "R6", "valid after idle", {wp_valid, fp_valid}, 0);
    // R10: last in-range word and the first out-of-range one
    step(1, 1, WORDS-1, 32'h0102_0304, 0, 0, "R10");
    step(1, 0, WORDS-1, 0, 1, MEM_BYTES-1, "R10");
    step(0, 0, 0, 0, 1, MEM_BYTES-4, "R10");
    step(1, 0, WORDS, 0, 0, 0, "R10");
    // R7: out-of-range read returns zero; write leaves memory unchanged
    step(1, 0, 255, 0, 0, 0, "R7");
    step(1, 1, WORDS, 32'hFFFF_FFFF, 0, 0, "R7");
    step(1, 1, 128, 32'hCAFE_F00D, 0, 0, "R7");
    step(1, 0, 0, 0, 0, 0, "R7");
    step(1, 0, WORDS-1, 0, 0, 0, "R7");
    // R8: out-of-range fetches
    step(0, 0, 0, 0, 1, MEM_BYTES, "R8");
    step(0, 0, 0, 0, 1, 511, "R8");
    // R9: same-cycle write and fetch of a byte in that word
    step(1, 1, 0, 32'h5566_7788, 1, 2, "R9");
    step(0, 0, 0, 0, 1, 2, "R9");
    // random mix, fixed seed
    void'($urandom(32'd4321));
    for (int n = 0; n < 3000; n++) begin
      int wa, fa;
      bit wr, wwe, fr;
      wr  = ($urandom % 4) != 0;
      wwe = $urandom % 2;
      fr  = ($urandom % 4) != 0;
      wa  = (($urandom % 16) == 0) ? int'($urandom % 256) : int'($urandom % WORDS);
      fa  = (($urandom % 16) == 0) ? int'($urandom % 512) : int'($urandom % MEM_BYTES);
      if (($urandom % 8) == 0 && wa < WORDS) fa = 4 * wa + int'($urandom % 4);
      step(wr, wwe, wa, $urandom, fr, fa, "R2/R4 random");
    end
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule